// File: doc/BRIEF.md
# PLL Divider Pair Search Engine

This block picks the feedback and reference divider settings of a frequency synthesiser that runs from a fixed 14.31818 MHz crystal. Software or a mode-setting sequencer presents a requested output frequency in hundredths of a megahertz and pulses a start input. The engine clamps the request, finds a power-of-two post-scale exponent by repeated doubling, then walks every allowed (M, N) pair. For each pair it works out the resulting output frequency through one shared shift-subtract divider and keeps the pair with the smallest error.

When the walk is over, the engine presents a 16-bit program word that packs N, the exponent and M, and raises a done flag. The word goes to a separate serialiser, which is not part of this block. Scan order and the strict-less comparison both decide which pair wins when two pairs tie, so both are fixed behaviour.

Top module: `pll_pair_search`

## Requirements
- R1: A request of 0 skips the search. Two clock edges after the start pulse is sampled, the word reads 0x00E0 and done is high.
- R2: A nonzero request is first limited to the range 8000 to 15938 (requests of 1 to 7999 act as 8000, and requests above 15938 act as 15938).
- R3: The error reference equals the limited request × 256 / 100, with integer truncation, taken before any doubling.
- R4: The exponent K equals the number of times the limited request is doubled while the value is still below 64000.
- R5: M steps upward from its minimum to its maximum in the outer loop, and N steps downward from its maximum to its minimum in the inner loop. A pair replaces the best so far only when its absolute error is strictly smaller, and the best error starts at 0xFFFFFFFF. Among equal errors, the first pair scanned wins.
- R6: The candidate frequency for each pair equals 938356 × (N + 8) / (2^K × 256 × (M + 2)), in unsigned 32-bit integer division.
- R7: The program word equals (K << 6) + M + (N << 8). N occupies bits 15:8, K occupies bits 7:6 and M occupies bits 5:0.
- R8: Done goes low on the edge that accepts a start and stays low through the whole scan. The word keeps its previous value until the scan ends. At the end, the new word and done appear on the same edge.
- R9: A start pulse that arrives while a search is running is ignored, along with the request presented with it. The running search finishes with its original request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Pulse that begins a search while the engine is idle |
| targetFreq | input | 16 | Requested frequency in units of 0.01 MHz, sampled with start |
| progWord | output | 16 | Packed N, K and M of the best pair |
| done | output | 1 | High once a result is ready, low while a search runs |

## Verification
The bench builds the engine with M limited to 2..9 and N limited to 70 down to 35. The frequency limits keep their defaults, so clamping and the doubling count behave as in the full-size engine. With 288 pairs, each search finishes in about ten thousand cycles, so a run has room for a dozen requests covering both clamp edges, the zero request, start pulses during a scan, and tie-breaking over a full outer loop. These ranges still exercise the wrap of N back to its maximum when M advances and the strict-less rule over many near-equal errors.

// File: rtl/pll_pair_search_pkg.sv
package pll_pair_search_pkg;
  typedef struct packed {
    logic load;
    logic dbl;
    logic divGo;
    logic eval;
    logic stepN;
    logic finish;
    logic zeroOut;
  } strobe_t;
endpackage

// File: rtl/pps_divider.sv
module pps_divider #(
  parameter int DIV_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             go,
  input  logic [DIV_W-1:0] numIn,
  input  logic [DIV_W-1:0] denIn,
  output logic [DIV_W-1:0] quo,
  output logic             fin
);
  localparam int CW = $clog2(DIV_W + 1);

  logic [DIV_W-1:0] remQ, quoQ, denQ;
  logic [CW-1:0]    cntQ;
  logic             busyQ, finQ;
  logic [DIV_W:0]   shifted;
  logic             fits;

  assign shifted = {remQ, quoQ[DIV_W-1]};
  assign fits    = shifted >= {1'b0, denQ};

  always_ff @(posedge clk) begin
    if (rst) begin
      remQ  <= '0;
      quoQ  <= '0;
      denQ  <= '0;
      cntQ  <= '0;
      busyQ <= 1'b0;
      finQ  <= 1'b0;
    end else if (go) begin
      remQ  <= '0;
      quoQ  <= numIn;
      denQ  <= denIn;
      cntQ  <= CW'(DIV_W);
      busyQ <= 1'b1;
      finQ  <= 1'b0;
    end else if (busyQ) begin
      remQ  <= fits ? DIV_W'(shifted - {1'b0, denQ}) : shifted[DIV_W-1:0];
      quoQ  <= {quoQ[DIV_W-2:0], fits};
      cntQ  <= cntQ - 1'b1;
      if (cntQ == CW'(1)) begin
        busyQ <= 1'b0;
        finQ  <= 1'b1;
      end
    end else begin
      finQ <= 1'b0;
    end
  end

  assign quo = quoQ;
  assign fin = finQ;

  // R6: a finished division always comes out of a running one
  p_div_fin_r6: assert property (@(posedge clk) disable iff (rst)
    finQ |-> $past(busyQ));
  // R6: the remainder stays below the divisor while running
  p_div_rem_r6: assert property (@(posedge clk) disable iff (rst)
    (busyQ && !go && denQ != '0) |-> remQ < denQ);
endmodule

// File: rtl/pps_ctrl.sv
module pps_ctrl
  import pll_pair_search_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    start,
  input  logic    isZero,
  input  logic    needDbl,
  input  logic    divFin,
  input  logic    lastN,
  input  logic    lastM,
  output strobe_t strb,
  output logic    busy
);
  typedef enum logic [1:0] {S_IDLE, S_CHECK, S_LAUNCH, S_DIV} state_t;
  state_t stateQ, stateD;

  always_comb begin
    stateD = stateQ;
    strb   = '0;
    case (stateQ)
      S_IDLE: if (start) begin
        strb.load = 1'b1;
        stateD    = S_CHECK;
      end
      S_CHECK: begin
        if (isZero) begin
          strb.zeroOut = 1'b1;
          stateD       = S_IDLE;
        end else if (needDbl) begin
          strb.dbl = 1'b1;
        end else begin
          stateD = S_LAUNCH;
        end
      end
      S_LAUNCH: begin
        strb.divGo = 1'b1;
        stateD     = S_DIV;
      end
      S_DIV: if (divFin) begin
        strb.eval = 1'b1;
        if (lastN && lastM) begin
          strb.finish = 1'b1;
          stateD      = S_IDLE;
        end else begin
          strb.stepN = 1'b1;
          stateD     = S_LAUNCH;
        end
      end
      default: stateD = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) stateQ <= S_IDLE;
    else     stateQ <= stateD;
  end

  assign busy = stateQ != S_IDLE;

  // R9: a start seen during a search never reloads the engine
  p_no_reload_r9: assert property (@(posedge clk) disable iff (rst)
    (busy && start) |=> !strb.load);
endmodule

// File: rtl/pps_dpath.sv
module pps_dpath
  import pll_pair_search_pkg::*;
#(
  parameter int FMIN  = 8000,
  parameter int FMAX  = 15938,
  parameter int MIN_M = 2,
  parameter int MAX_M = 30,
  parameter int MIN_N = 35,
  parameter int MAX_N = 247,
  parameter int DIV_W = 32
) (
  input  logic        clk,
  input  logic        rst,
  input  strobe_t     strb,
  input  logic [15:0] targetFreq,
  output logic        isZero,
  output logic        needDbl,
  output logic        divFin,
  output logic        lastN,
  output logic        lastM,
  output logic [15:0] progWord,
  output logic        done
);
  localparam int MW = $clog2(MAX_M + 1);
  localparam int NW = $clog2(MAX_N + 1);
  localparam logic [31:0] REF_SCALED = 32'd938356;
  localparam logic [31:0] DBL_LIMIT  = 32'(FMIN) * 32'd8;

  logic [15:0]      clampIn;
  logic [31:0]      longQ, workQ, bestQ, diff;
  logic [1:0]       kQ;
  logic [MW-1:0]    mQ, sMQ;
  logic [NW-1:0]    nQ, sNQ;
  logic             zeroQ, doneQ;
  logic [15:0]      wordQ;
  logic [DIV_W-1:0] numV, denV, quo;

  always_comb begin
    if (targetFreq < 16'(FMIN))      clampIn = 16'(FMIN);
    else if (targetFreq > 16'(FMAX)) clampIn = 16'(FMAX);
    else                             clampIn = targetFreq;
  end

  assign numV = DIV_W'(REF_SCALED * (32'(nQ) + 32'd8));
  assign denV = DIV_W'((32'(mQ) + 32'd2) << (32'(kQ) + 32'd8));

  pps_divider #(.DIV_W(DIV_W)) u_div (
    .clk(clk), .rst(rst), .go(strb.divGo),
    .numIn(numV), .denIn(denV), .quo(quo), .fin(divFin)
  );

  assign diff    = (longQ > 32'(quo)) ? longQ - 32'(quo) : 32'(quo) - longQ;
  assign isZero  = zeroQ;
  assign needDbl = workQ < DBL_LIMIT;
  assign lastN   = nQ == NW'(MIN_N);
  assign lastM   = mQ == MW'(MAX_M);

  always_ff @(posedge clk) begin
    if (rst) begin
      longQ <= '0;
      workQ <= '0;
      bestQ <= '1;
      kQ    <= '0;
      mQ    <= MW'(MIN_M);
      nQ    <= NW'(MAX_N);
      sMQ   <= '0;
      sNQ   <= '0;
      zeroQ <= 1'b0;
      doneQ <= 1'b0;
      wordQ <= '0;
    end else begin
      if (strb.load) begin
        zeroQ <= targetFreq == 16'd0;
        longQ <= 32'(clampIn) * 32'd256 / 32'd100;
        workQ <= 32'(clampIn);
        kQ    <= '0;
        bestQ <= '1;
        mQ    <= MW'(MIN_M);
        nQ    <= NW'(MAX_N);
        doneQ <= 1'b0;
      end
      if (strb.dbl) begin
        workQ <= workQ << 1;
        kQ    <= kQ + 1'b1;
      end
      if (strb.eval && diff < bestQ) begin
        bestQ <= diff;
        sMQ   <= mQ;
        sNQ   <= nQ;
      end
      if (strb.stepN) begin
        if (lastN) begin
          nQ <= NW'(MAX_N);
          mQ <= mQ + 1'b1;
        end else begin
          nQ <= nQ - 1'b1;
        end
      end
      if (strb.finish) begin
        wordQ <= 16'((32'(kQ) << 6) + 32'((strb.eval && diff < bestQ) ? mQ : sMQ)
                 + (32'((strb.eval && diff < bestQ) ? nQ : sNQ) << 8));
        doneQ <= 1'b1;
      end
      if (strb.zeroOut) begin
        wordQ <= 16'h00E0;
        doneQ <= 1'b1;
      end
    end
  end

  assign progWord = wordQ;
  assign done     = doneQ;

  // R4: the scan starts only once doubling has reached the limit
  p_scaled_r4: assert property (@(posedge clk) disable iff (rst)
    strb.divGo |-> workQ >= DBL_LIMIT);
  // R5: the best error never grows during a scan
  p_best_mono_r5: assert property (@(posedge clk) disable iff (rst)
    (strb.eval && !strb.load) |=> bestQ <= $past(bestQ));
  // R5: loop indices stay inside their ranges
  p_index_range_r5: assert property (@(posedge clk) disable iff (rst)
    mQ >= MW'(MIN_M) && mQ <= MW'(MAX_M) && nQ >= NW'(MIN_N) && nQ <= NW'(MAX_N));
endmodule

// File: rtl/pll_pair_search.sv
module pll_pair_search
  import pll_pair_search_pkg::*;
#(
  parameter int FMIN  = 8000,
  parameter int FMAX  = 15938,
  parameter int MIN_M = 2,
  parameter int MAX_M = 30,
  parameter int MIN_N = 35,
  parameter int MAX_N = 247,
  parameter int DIV_W = 32
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        start,
  input  logic [15:0] targetFreq,
  output logic [15:0] progWord,
  output logic        done
);
  strobe_t strb;
  logic isZero, needDbl, divFin, lastN, lastM, busy;

  pps_ctrl u_ctrl (
    .clk(clk), .rst(rst), .start(start), .isZero(isZero), .needDbl(needDbl),
    .divFin(divFin), .lastN(lastN), .lastM(lastM), .strb(strb), .busy(busy)
  );

  pps_dpath #(
    .FMIN(FMIN), .FMAX(FMAX), .MIN_M(MIN_M), .MAX_M(MAX_M),
    .MIN_N(MIN_N), .MAX_N(MAX_N), .DIV_W(DIV_W)
  ) u_dpath (
    .clk(clk), .rst(rst), .strb(strb), .targetFreq(targetFreq),
    .isZero(isZero), .needDbl(needDbl), .divFin(divFin), .lastN(lastN),
    .lastM(lastM), .progWord(progWord), .done(done)
  );

  // R8: done stays low while the control is running a search
  p_done_low_r8: assert property (@(posedge clk) disable iff (rst)
    busy |-> !done);
  // R8: the word does not move while a search is in progress
  p_word_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> $stable(progWord));
endmodule

// File: tb/sim_pll_pair_search.sv
module sim_pll_pair_search;
  localparam int T_MIN_M = 2;
  localparam int T_MAX_M = 9;
  localparam int T_MIN_N = 35;
  localparam int T_MAX_N = 70;
  localparam int NVEC = 10;
  localparam logic [15:0] VEC [NVEC] = '{16'd0, 16'd5000, 16'd8000, 16'd10000, 16'd12345,
                                         16'd15938, 16'd20000, 16'd9000, 16'd14318, 16'd1};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [15:0] targetFreq = '0;
  logic [15:0] progWord;
  logic done;
  int nRun = 0;
  int nFail = 0;
  int cyc = 0;
  bit timedOut = 1'b0;

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  pll_pair_search #(.MIN_M(T_MIN_M), .MAX_M(T_MAX_M), .MIN_N(T_MIN_N), .MAX_N(T_MAX_N)) u0 (
    .clk(clk), .rst(rst), .start(start), .targetFreq(targetFreq),
    .progWord(progWord), .done(done)
  );

  function automatic logic [15:0] model(input int t);
    longint c, lt, w, best, f, d;
    int k, sm, sn;
    if (t == 0) return 16'h00E0;
    c = (t < 8000) ? 8000 : (t > 15938) ? 15938 : t;
    lt = c * 256 / 100;
    w = c;
    k = 0;
    while (w < 64000) begin w = w * 2; k++; end
    best = 64'hFFFFFFFF;
    sm = 0;
    sn = 0;
    for (int m = T_MIN_M; m <= T_MAX_M; m++)
      for (int n = T_MAX_N; n >= T_MIN_N; n--) begin
        f = (longint'(938356) * (n + 8)) / ((longint'(1) << k) * 256 * (m + 2));
        d = (lt > f) ? lt - f : f - lt;
        if (d < best) begin best = d; sm = m; sn = n; end
      end
    return 16'((k << 6) + sm + (sn << 8));
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic pulse(input logic [15:0] t);
    @(negedge clk);
    targetFreq = t;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic waitDone();
    int lim = 0;
    while (!done && lim < 20000) begin @(negedge clk); lim++; end
    if (!done) begin nRun++; nFail++; $display("FAIL R8 actual=done0 expected=done1"); end
  endtask

  initial begin
    logic [15:0] prev;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R8 reset done", 32'(done), 32'd0);
    check("R7 reset word", 32'(progWord), 32'd0);

    // R1: zero request gives 0x00E0 two edges after start is sampled
    @(negedge clk);
    targetFreq = 16'd0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    check("R1 zero word", 32'(progWord), 32'h00E0);
    check("R1 zero done", 32'(done), 32'd1);

    for (int i = 0; i < NVEC; i++) begin
      prev = progWord;
      pulse(VEC[i]);
      if (VEC[i] != 16'd0) begin
        repeat (50) @(negedge clk);
        check("R8 done low in scan", 32'(done), 32'd0);
        check("R8 word held in scan", 32'(progWord), 32'(prev));
      end
      waitDone();
      check("R2 R3 R4 R5 R6 R7 vector", 32'(progWord), 32'(model(int'(VEC[i]))));
    end

    // R9: a start during a running search is ignored
    pulse(16'd10000);
    repeat (100) @(negedge clk);
    pulse(16'd15938);
    targetFreq = 16'd0;
    waitDone();
    check("R9 start ignored", 32'(progWord), 32'(model(10000)));
    repeat (3) @(negedge clk);
    check("R9 stays done", 32'(done), 32'd1);

    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    wait (cyc >= 195000);
    timedOut = 1'b1;
    nRun++;
    nFail++;
    $display("FAIL watchdog actual=%0d expected=finish", cyc);
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule